// File: doc/BRIEF.md
# Two-Stage SPI Baud Rate Divider

This block derives the serial clock timing for an SPI master from the module clock. A 6-bit rate word holds two fields: a 3-bit linear preselect and a 3-bit power-of-two select. Together they give a divisor of (preselect+1) × 2^(select+1) module-clock cycles for each full SCK period. Because the preselect factor is linear (1 to 8) and the select factor is a power of two (2 to 256), ratios that are not powers of two are possible, such as 6 and 10.

The output is a single-cycle toggle strobe. It fires once per half SCK period, and the transfer engine uses it to flip SCK. The divider counts only while the port is master and a transfer is running. Otherwise its counter is held cleared, which keeps it quiet to save power.

The rate word is captured while the divider is idle. A transfer already under way keeps the rate it started with. A new setting takes effect from the next transfer.

Top module: `spi_baud_gen`

## Requirements
- R1: While reset (`rst_ni` low) is asserted and in the first cycle after it, `sck_tgl_o` is low.
- R2: The rate word is split as `rate_i[2:0]` = select S and `rate_i[5:3]` = preselect P. While enabled, `sck_tgl_o` pulses once every H = (P+1)·2^S module-clock cycles. This half period corresponds to a full SCK divisor of (P+1)·2^(S+1).
- R3: With P=0 and S=0 (divide by 2), `sck_tgl_o` is high on every cycle while enabled.
- R4: The divider is enabled only when `master_i` and `xfer_active_i` are both high. After any clock edge at which either is low, `sck_tgl_o` is low.
- R5: After an idle period, the first pulse appears after the H-th rising edge at which the divider is enabled, so the first half period has full length.
- R6: The rate word is sampled at the last idle edge before a transfer. Changes made while enabled have no effect on the pulse spacing until the divider has been idle again.
- R7: When H > 1, `sck_tgl_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 6 | Rate word: [5:3] preselect, [2:0] select |
| master_i | input | 1 | High when the port operates as master |
| xfer_active_i | input | 1 | High while a transfer is in progress |
| sck_tgl_o | output | 1 | One-cycle strobe at each SCK half-period boundary |

## Verification
The checks rely on at least one idle edge (master or transfer-active low) between reset release and the first transfer. That edge is where the rate word is captured, and the bench always holds the divider idle for a few cycles before raising the transfer flag. They also take the rate word to be stable at the idle edge preceding a transfer. The bench changes it only on falling edges, and deliberately while a transfer is running, so that the ignored-change behaviour is exercised. Settings are drawn at random across the full 6-bit range, and transfer lengths are bounded to a few half periods so that the largest divisor still fits the run.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

    localparam int unsigned PRE_W_DEF = 3;
    localparam int unsigned SEL_W_DEF = 3;

    // Half-period length in module-clock cycles for given field values
    function automatic int unsigned half_len(input int unsigned pre, input int unsigned sel);
        return (pre + 1) << sel;
    endfunction

endpackage

// File: rtl/spi_baud_decode.sv
module spi_baud_decode #(
    parameter int unsigned PRE_W  = 3,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned HALF_W = PRE_W + (2 ** SEL_W)
) (
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [HALF_W-1:0] half_o
);

    localparam int unsigned NSEL = 2 ** SEL_W;

    logic [HALF_W-1:0] lin_factor;
    logic [HALF_W-1:0] cand [NSEL];

    assign lin_factor = {{(HALF_W-PRE_W){1'b0}}, pre_i} + HALF_W'(1);

    // One shifted candidate per select value; the select field picks one
    for (genvar s = 0; s < NSEL; s++) begin : g_cand
        assign cand[s] = lin_factor << s;
    end

    assign half_o = cand[sel_i];

endmodule

// File: rtl/spi_baud_counter.sv
module spi_baud_counter #(
    parameter int unsigned HALF_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              stb_o
);

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [HALF_W-1:0] cnt;
        logic              stb;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!en_i) begin
            // Idle: hold counter clear and track the requested rate
            st_d.cnt  = '0;
            st_d.half = half_i;
        end else if (st_q.cnt == st_q.half - HALF_W'(1)) begin
            st_d.cnt = '0;
            st_d.stb = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.half <= HALF_W'(1);
            st_q.cnt  <= '0;
            st_q.stb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = st_q.stb;

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int unsigned PRE_W = spi_baud_pkg::PRE_W_DEF,
    parameter int unsigned SEL_W = spi_baud_pkg::SEL_W_DEF
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [PRE_W+SEL_W-1:0] rate_i,
    input  logic                   master_i,
    input  logic                   xfer_active_i,
    output logic                   sck_tgl_o
);

    localparam int unsigned HALF_W = PRE_W + (2 ** SEL_W);

    logic              run_en;
    logic [HALF_W-1:0] half_len;

    assign run_en = master_i & xfer_active_i;

    spi_baud_decode #(
        .PRE_W  (PRE_W),
        .SEL_W  (SEL_W),
        .HALF_W (HALF_W)
    ) u_decode (
        .pre_i  (rate_i[PRE_W+SEL_W-1:SEL_W]),
        .sel_i  (rate_i[SEL_W-1:0]),
        .half_o (half_len)
    );

    spi_baud_counter #(
        .HALF_W (HALF_W)
    ) u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (run_en),
        .half_i (half_len),
        .stb_o  (sck_tgl_o)
    );

endmodule

// File: rtl/spi_baud_chk.sv
module spi_baud_chk #(
    parameter int unsigned PRE_W = 3,
    parameter int unsigned SEL_W = 3
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [PRE_W+SEL_W-1:0] rate_i,
    input logic                   master_i,
    input logic                   xfer_active_i,
    input logic                   sck_tgl_o
);

    localparam int unsigned HALF_W = PRE_W + (2 ** SEL_W);

    logic              en;
    logic [HALF_W-1:0] ref_half;
    logic [HALF_W-1:0] ref_cnt;
    logic              ref_stb;

    assign en = master_i & xfer_active_i;

    // Independent timing reference built from the port-level rules
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_half <= HALF_W'(1);
            ref_cnt  <= '0;
            ref_stb  <= 1'b0;
        end else if (!en) begin
            ref_half <= HALF_W'(spi_baud_pkg::half_len(
                            int'(rate_i[PRE_W+SEL_W-1:SEL_W]), int'(rate_i[SEL_W-1:0])));
            ref_cnt  <= '0;
            ref_stb  <= 1'b0;
        end else if (ref_cnt + HALF_W'(1) == ref_half) begin
            ref_cnt  <= '0;
            ref_stb  <= 1'b1;
        end else begin
            ref_cnt  <= ref_cnt + HALF_W'(1);
            ref_stb  <= 1'b0;
        end
    end

    // R2 R5 R6
    strobe_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sck_tgl_o == ref_stb);

    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en |=> !sck_tgl_o);

    // R3
    fastest_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en && !$past(en) && $past(rate_i) == '0) |=> sck_tgl_o);

    // R7
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sck_tgl_o && ref_half != HALF_W'(1)) |=> !sck_tgl_o);

    // R1
    reset_low_chk: assert property (@(posedge clk_i)
        !rst_ni |=> !sck_tgl_o);

endmodule

bind spi_baud_gen spi_baud_chk #(
    .PRE_W (PRE_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rate_i        (rate_i),
    .master_i      (master_i),
    .xfer_active_i (xfer_active_i),
    .sck_tgl_o     (sck_tgl_o)
);

// File: tb/tb_spi_baud_gen.sv
module tb_spi_baud_gen;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [5:0] rate_i = '0;
    logic       master_i = 1'b0;
    logic       xfer_active_i = 1'b0;
    logic       sck_tgl_o;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned seed_v;

    spi_baud_gen dut (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .rate_i        (rate_i),
        .master_i      (master_i),
        .xfer_active_i (xfer_active_i),
        .sck_tgl_o     (sck_tgl_o)
    );

    always #10 clk_i = ~clk_i;

    function automatic int unsigned exp_half(input int unsigned pre, input int unsigned sel);
        return (pre + 1) * (1 << sel);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: sck_tgl_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Idle a few cycles, then run a transfer of len enabled edges.
    // If chg is set, the rate word is changed halfway through.
    task automatic run_xfer(input int unsigned pre, input int unsigned sel,
                            input int unsigned len, input bit chg, input string req);
        int unsigned h = exp_half(pre, sel);
        @(negedge clk_i);
        master_i = 1'b1;
        xfer_active_i = 1'b0;
        rate_i = {pre[2:0], sel[2:0]};
        repeat (2) begin
            @(negedge clk_i);
            check("R4", sck_tgl_o, 1'b0);
        end
        xfer_active_i = 1'b1;
        for (int unsigned k = 1; k <= len; k++) begin
            @(negedge clk_i);
            check(req, sck_tgl_o, (k % h) == 0);
            if (chg && k == len / 2) rate_i = ~rate_i;
        end
        xfer_active_i = 1'b0;
        @(negedge clk_i);
        check("R4", sck_tgl_o, 1'b0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        seed_v = 32'd1234;
        void'($urandom(seed_v));
        repeat (3) begin
            @(negedge clk_i);
            check("R1", sck_tgl_o, 1'b0);
        end
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", sck_tgl_o, 1'b0);

        // R3: divide by 2, pulse each cycle
        run_xfer(0, 0, 8, 1'b0, "R3");
        // R2: non-power-of-two ratios 6 and 10 (half periods 3 and 5)
        run_xfer(2, 0, 15, 1'b0, "R2");
        run_xfer(4, 0, 20, 1'b0, "R2");
        // R5: first half period full length, R7 single pulses
        run_xfer(0, 3, 30, 1'b0, "R5");
        run_xfer(1, 1, 12, 1'b0, "R7");
        // R6: change while running ignored, next transfer uses new value
        run_xfer(1, 2, 40, 1'b1, "R6");
        run_xfer(3, 1, 24, 1'b1, "R6");
        run_xfer(0, 0, 6, 1'b0, "R6");
        // R2: largest divisor
        run_xfer(7, 7, 2100, 1'b0, "R2");

        // R4: master low blocks counting even with transfer flag high
        @(negedge clk_i);
        rate_i = '0;
        master_i = 1'b0;
        xfer_active_i = 1'b1;
        repeat (6) begin
            @(negedge clk_i);
            check("R4", sck_tgl_o, 1'b0);
        end
        xfer_active_i = 1'b0;

        // R2 R6 R7: random settings, bounded lengths
        for (int i = 0; i < 24; i++) begin
            int unsigned p = $urandom_range(7, 0);
            int unsigned s = $urandom_range(7, 0);
            int unsigned h = exp_half(p, s);
            int unsigned l = 2 * h + $urandom_range(h, 1);
            run_xfer(p, s, l, bit'($urandom_range(1, 0)), "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule